// File: doc/BRIEF.md
# Ringing-to-Talk Transition Sequencer

This block sits on the host side of a subscriber line switch and drives its two mode-select inputs and its open-drain shutdown line. The host hands it one command at a time. A command either puts the switch into the ringing state or moves it from ringing to talk in one of three ways. The first changes the mode inputs directly. The second parks the switch in the all-off state for a programmed hold time before it applies talk. The third pulls the shutdown line low for the hold time, loads the talk inputs while the line is still low, and then lets the line go.

The hold time is a count of clock ticks. Software sets it to cover at least half a ringing period, so that the ringing switch has passed a zero-current point and opened before the talk path closes. The hold value and the command code are captured when the command is accepted. Inputs that change after that point have no effect on the sequence already running.

Commands arrive on a valid/ready interface. A command is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low for the whole time a sequence is running. While `req_ready` is low, a command offered on the interface is not taken. The requester may hold the command until `req_ready` returns or may withdraw it. The outputs have no back-pressure.

Top module: `rtt_sequencer`

## Requirements
- R1: After reset the mode outputs are all-off (`sw_ring`=1, `sw_test`=1), `shdn_pull_low`=0 (line released), `busy`=0, `done`=0 and `req_ready`=1.
- R2: An accepted command with code 0 (ringing) drives (1,0) on (`sw_ring`,`sw_test`) in the cycle after acceptance, with a one-cycle `done` pulse in that same cycle.
- R3: An accepted command with code 1 (make-before-break) drives talk (0,0) in the cycle after acceptance, with no intermediate state and with a one-cycle `done` pulse in that same cycle.
- R4: An accepted command with code 2 (mode-input break-before-make) drives (1,1) from the cycle after acceptance. The all-off state stays for exactly Hc cycles, where Hc is the accepted hold value (see R9). In the following cycle the outputs go to (0,0) and `done` pulses.
- R5: An accepted command with code 3 (shutdown-line break-before-make) raises `shdn_pull_low` in the cycle after acceptance and leaves the mode outputs unchanged. Hc cycles later the mode outputs go to (0,0) while `shdn_pull_low` is still 1.
- R6: In code 3, `shdn_pull_low` returns to 0 (line released to high impedance, never driven high) one cycle after the mode outputs reach (0,0). `done` pulses in that release cycle.
- R7: The command code and the hold value are captured at acceptance. Changes on `req_mode` or `req_hold` during a running sequence do not alter it.
- R8: `busy` is 1 from the cycle after a code 2 or 3 command is accepted until the cycle of its `done` pulse. In that `done` cycle `busy` is 0. `req_ready` is the inverse of `busy`. A command offered while `busy` is 1 is ignored.
- R9: A hold value of 0 is treated as 1, so Hc = max(`req_hold`, 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Command offered |
| req_ready | output | 1 | Command can be taken (idle) |
| req_mode | input | 2 | Command code: 0 ringing, 1 make-before-break, 2 all-off hold, 3 shutdown-line hold |
| req_hold | input | HOLD_W | Hold time in clock ticks |
| sw_ring | output | 1 | First mode-select input of the switch |
| sw_test | output | 1 | Second mode-select input of the switch |
| shdn_pull_low | output | 1 | 1 pulls the open-drain shutdown line low; 0 releases it |
| busy | output | 1 | A timed sequence is running |
| done | output | 1 | One-cycle pulse when the final state is in place |

## Verification
Every result is due a fixed number of cycles after acceptance:
- Codes 0 and 1 finish one cycle after the edge that accepts them.
- Code 2 gives talk at Hc+1 cycles.
- Code 3 gives talk under the pulled line at Hc+1 cycles and releases the line at Hc+2 cycles.

A behavioural model in the bench turns each accepted command into a queue of expected per-cycle output frames. It pops one frame per rising edge and compares all outputs at every falling edge. Directed checks also count falling edges from the accepting edge to those exact latencies, including the case Hc=1 that comes from a hold value of 0.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
  typedef enum logic [1:0] {
    CMD_RING = 2'd0,
    CMD_MBB  = 2'd1,
    CMD_BBM  = 2'd2,
    CMD_SHDN = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ALLOFF = 2'd1,
    ST_PULL   = 2'd2,
    ST_REL    = 2'd3
  } state_e;

  typedef struct packed {
    logic ring;
    logic test;
  } sel_pair_t;

  localparam sel_pair_t PAIR_ALLOFF = '{ring: 1'b1, test: 1'b1};
  localparam sel_pair_t PAIR_RING   = '{ring: 1'b1, test: 1'b0};
  localparam sel_pair_t PAIR_TALK   = '{ring: 1'b0, test: 1'b0};
endpackage

// File: rtl/rtt_hold_timer.sv
module rtt_hold_timer #(
  parameter int HOLD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [HOLD_W-1:0] load_val,
  input  logic              dec,
  output logic              last
);
  localparam logic [HOLD_W-1:0] ONE = HOLD_W'(1);

  logic [HOLD_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= ONE;
    end else if (load) begin
      cnt <= (load_val == '0) ? ONE : load_val;
    end else if (dec) begin
      cnt <= cnt - ONE;
    end
  end

  assign last = (cnt == ONE);
endmodule

// File: rtl/rtt_ctrl.sv
module rtt_ctrl
  import rtt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic [1:0] cmd,
  input  logic       tmr_last,
  output logic       tmr_load,
  output logic       tmr_dec,
  output logic       sw_ring,
  output logic       sw_test,
  output logic       pull_low,
  output logic       busy,
  output logic       done
);
  state_e    st;
  sel_pair_t sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      sel      <= PAIR_ALLOFF;
      pull_low <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            unique case (cmd_e'(cmd))
              CMD_RING: begin
                sel  <= PAIR_RING;
                done <= 1'b1;
              end
              CMD_MBB: begin
                sel  <= PAIR_TALK;
                done <= 1'b1;
              end
              CMD_BBM: begin
                sel <= PAIR_ALLOFF;
                st  <= ST_ALLOFF;
              end
              CMD_SHDN: begin
                pull_low <= 1'b1;
                st       <= ST_PULL;
              end
            endcase
          end
        end
        ST_ALLOFF: begin
          if (tmr_last) begin
            sel  <= PAIR_TALK;
            done <= 1'b1;
            st   <= ST_IDLE;
          end
        end
        ST_PULL: begin
          if (tmr_last) begin
            sel <= PAIR_TALK;
            st  <= ST_REL;
          end
        end
        ST_REL: begin
          pull_low <= 1'b0;
          done     <= 1'b1;
          st       <= ST_IDLE;
        end
      endcase
    end
  end

  assign tmr_load = accept && (st == ST_IDLE);
  assign tmr_dec  = ((st == ST_ALLOFF) || (st == ST_PULL)) && !tmr_last;
  assign busy     = (st != ST_IDLE);
  assign sw_ring  = sel.ring;
  assign sw_test  = sel.test;
endmodule

// File: rtl/rtt_sequencer.sv
module rtt_sequencer #(
  parameter int HOLD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_mode,
  input  logic [HOLD_W-1:0] req_hold,
  output logic              sw_ring,
  output logic              sw_test,
  output logic              shdn_pull_low,
  output logic              busy,
  output logic              done
);
  logic accept;
  logic tmr_load;
  logic tmr_dec;
  logic tmr_last;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  rtt_hold_timer #(.HOLD_W(HOLD_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (req_hold),
    .dec      (tmr_dec),
    .last     (tmr_last)
  );

  rtt_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .cmd      (req_mode),
    .tmr_last (tmr_last),
    .tmr_load (tmr_load),
    .tmr_dec  (tmr_dec),
    .sw_ring  (sw_ring),
    .sw_test  (sw_test),
    .pull_low (shdn_pull_low),
    .busy     (busy),
    .done     (done)
  );
endmodule

// File: rtl/rtt_sequencer_chk.sv
module rtt_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [1:0] req_mode,
  input logic       sw_ring,
  input logic       sw_test,
  input logic       shdn_pull_low,
  input logic       busy,
  input logic       done
);
  logic acc;
  assign acc = req_valid && req_ready;

  a_r2_ring_entry: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_mode == 2'd0 |=> sw_ring && !sw_test && done);

  a_r3_mbb_direct: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_mode == 2'd1 |=> !sw_ring && !sw_test && done);

  a_r4_alloff_first: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_mode == 2'd2 |=> sw_ring && sw_test && busy && !done);

  a_r5_pull_first: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_mode == 2'd3 |=> shdn_pull_low && $stable({sw_ring, sw_test}) && busy);

  a_r6_release_after_talk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shdn_pull_low) |-> !sw_ring && !sw_test && done && $past(!sw_ring && !sw_test));

  a_r8_pull_only_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shdn_pull_low) |-> $past(acc && req_mode == 2'd3));

  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind rtt_sequencer rtt_sequencer_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_mode      (req_mode),
  .sw_ring       (sw_ring),
  .sw_test       (sw_test),
  .shdn_pull_low (shdn_pull_low),
  .busy          (busy),
  .done          (done)
);

// File: tb/sim_rtt_sequencer.sv
`timescale 1ns/1ps
module sim_rtt_sequencer;
  localparam int HW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_mode = 2'd0;
  logic [HW-1:0] req_hold = '0;
  logic          req_ready, sw_ring, sw_test, shdn_pull_low, busy, done;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  rtt_sequencer #(.HOLD_W(HW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_hold(req_hold), .sw_ring(sw_ring), .sw_test(sw_test),
    .shdn_pull_low(shdn_pull_low), .busy(busy), .done(done)
  );

  typedef struct {bit r; bit t; bit p; bit d; bit b;} frame_t;
  frame_t fq[$];
  frame_t cur = '{1, 1, 0, 0, 0};

  always @(posedge clk) begin
    if (!rst_n) begin
      cur = '{1, 1, 0, 0, 0};
      fq.delete();
    end else begin
      if (req_valid && !cur.b) begin
        int h;
        h = (req_hold == 0) ? 1 : int'(req_hold);
        case (req_mode)
          2'd0: fq.push_back('{1, 0, 0, 1, 0});
          2'd1: fq.push_back('{0, 0, 0, 1, 0});
          2'd2: begin
            for (int i = 0; i < h; i++) fq.push_back('{1, 1, 0, 0, 1});
            fq.push_back('{0, 0, 0, 1, 0});
          end
          default: begin
            for (int i = 0; i < h; i++) fq.push_back('{cur.r, cur.t, 1, 0, 1});
            fq.push_back('{0, 0, 1, 0, 1});
            fq.push_back('{0, 0, 0, 1, 0});
          end
        endcase
      end
      if (fq.size() > 0) cur = fq.pop_front();
      else begin
        cur.d = 0;
        cur.b = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual {ring,test,pull,done,busy,ready}=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] outs();
    return {sw_ring, sw_test, shdn_pull_low, done, busy, req_ready};
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      logic [5:0] e;
      e = {cur.r, cur.t, cur.p, cur.d, cur.b, !cur.b};
      chk(outs() === e, {cur_req, " model"}, outs(), e);
    end
  end

  task automatic send(input logic [1:0] m, input int h);
    @(negedge clk);
    req_valid = 1'b1;
    req_mode  = m;
    req_hold  = HW'(h);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(outs() === 6'b110001, "R1", outs(), 6'b110001);

    cur_req = "R2";
    send(2'd0, 0);
    chk(outs() === 6'b100101, "R2", outs(), 6'b100101);
    @(negedge clk);
    chk(done === 1'b0, "R2 done one cycle", outs(), 6'b100001);

    cur_req = "R3";
    send(2'd1, 0);
    chk(outs() === 6'b000101, "R3", outs(), 6'b000101);

    cur_req = "R4";
    send(2'd0, 0);
    send(2'd2, 5);
    chk(outs() === 6'b110010, "R4 alloff", outs(), 6'b110010);
    repeat (4) @(negedge clk);
    chk(outs() === 6'b110010, "R4 still alloff", outs(), 6'b110010);
    @(negedge clk);
    chk(outs() === 6'b000101, "R4 talk", outs(), 6'b000101);

    cur_req = "R7";
    send(2'd0, 0);
    send(2'd2, 6);
    req_valid = 1'b1;
    req_mode  = 2'd3;
    req_hold  = HW'(1);
    repeat (3) @(negedge clk);
    chk(shdn_pull_low === 1'b0, "R8 ignored while busy", outs(), 6'b110010);
    chk(outs() === 6'b110010, "R7 hold not reloaded", outs(), 6'b110010);
    req_valid = 1'b0;
    n = 3;
    while (sw_ring && sw_test && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk(n == 6, "R7 latched hold length", {2'b0, 4'(n)}, 6'd6);

    cur_req = "R5";
    send(2'd0, 0);
    send(2'd3, 4);
    chk(outs() === 6'b101010, "R5 pull first", outs(), 6'b101010);
    repeat (3) @(negedge clk);
    chk(outs() === 6'b101010, "R5 pull held", outs(), 6'b101010);
    @(negedge clk);
    chk(outs() === 6'b001010, "R5 talk under pull", outs(), 6'b001010);
    cur_req = "R6";
    @(negedge clk);
    chk(outs() === 6'b000101, "R6 release", outs(), 6'b000101);

    cur_req = "R9";
    send(2'd2, 0);
    chk(outs() === 6'b110010, "R9 alloff", outs(), 6'b110010);
    @(negedge clk);
    chk(outs() === 6'b000101, "R9 talk after one", outs(), 6'b000101);
    send(2'd3, 0);
    chk(outs() === 6'b001010, "R9 pull", outs(), 6'b001010);
    @(negedge clk);
    @(negedge clk);
    chk(outs() === 6'b000101, "R9 release", outs(), 6'b000101);

    cur_req = "R8";
    send(2'd1, 0);
    send(2'd0, 0);
    chk(outs() === 6'b100101, "R8 back to back", outs(), 6'b100101);
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule